// File: doc/BRIEF.md
# Sprite Page Copy Engine with CPU Stall

This block copies one 256-byte page of CPU address space into the sprite attribute data port. A CPU write to the trigger address arms it and supplies the source page number. The engine then asks the CPU to stop by raising a halt request. A halt can only take hold on a CPU read cycle, so the request waits through any CPU write cycles, such as the back-to-back writes that close a read-modify-write instruction.

The CPU read cycle that is caught by the halt still runs on the bus, and its data is thrown away. A free-running parity flop tells apart the two kinds of cycle, the get cycle and the put cycle. If the halt lands on a put cycle, one alignment cycle is added before the copy starts. During that cycle the CPU stays halted and keeps its read address on the bus.

The engine then owns the bus. It reads byte n of the page, writes that byte to the sprite data port, and repeats this for n = 0x00 up to 0xFF. After the last write it drops the halt, and the CPU repeats the read that was stalled.

Top module: `spr_dma`

## Requirements
- R1: Synchronous reset, at any time, returns the block to idle with `halt` = 0 and `dma_active` = 0. The cycle parity goes back to get, which is encoded as 0.
- R2: A CPU write (`cpu_rw` = 0) to address 0x4014 while idle raises `halt` in the next cycle. A CPU read of 0x4014, or a write to any other address, leaves `halt` at 0.
- R3: While `halt` is waiting and the CPU is writing (`cpu_rw` = 0), the request keeps waiting and the engine does not take the bus (`dma_active` = 0).
- R4: Every CPU write to 0x4014 made while idle or waiting loads the source page from `cpu_wdata`. The last such write decides which page is copied.
- R5: The first CPU read cycle with `halt` high is the halted cycle. In that cycle the bus stays with the CPU (`dma_active` = 0), and the engine does not use the data read.
- R6: The parity flop alternates every cycle after reset. Cycle k after reset has parity k mod 2, with 1 = put. If the halted cycle has parity 1, exactly one extra cycle follows with `halt` = 1 and `dma_active` = 0. If it has parity 0, no extra cycle is added.
- R7: The copy is exactly 256 pairs, one pair per n = 0x00 to 0xFF in order. Each pair is a read cycle (`dma_rw` = 1, `dma_addr` = {page, n}) followed by a write cycle (`dma_rw` = 0, `dma_addr` = 0x2004, `dma_wdata` = the byte read).
- R8: `halt` falls in the cycle after the last write. The total number of cycles with `halt` high is: waiting write cycles + 1 + alignment (0 or 1) + 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one CPU bus cycle per clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Address the CPU drives on the bus |
| cpu_rw | input | 1 | CPU cycle type, 1 = read, 0 = write |
| cpu_wdata | input | 8 | CPU write data |
| bus_rdata | input | 8 | Read data returned by the shared bus |
| halt | output | 1 | Stall request to the CPU; takes hold only on a read cycle |
| dma_active | output | 1 | Engine owns the bus this cycle |
| dma_addr | output | 16 | Engine bus address |
| dma_rw | output | 1 | Engine cycle type, 1 = read, 0 = write |
| dma_wdata | output | 8 | Engine write data |

## Verification
The bench sends triggers followed by zero, one or two CPU write cycles. It lines each case up so that the halted read lands on a get cycle in some runs and a put cycle in others, and it counts the cycles with `halt` high and the cycles with `halt` high but the bus not yet taken.

Each kind of defect shows up in a different measurement:
- A design that halts on a write cycle makes that count too short.
- A design that ignores parity, or reads it from the wrong cycle, is off by one stall cycle in half of the cases.
- A design that copies the wrong page, or skips the first or last byte, shows up as an address or data mismatch, or as a pair count other than 256.
- A design that ignores a repeated trigger write copies the wrong page.
- A design that arms on a read of the trigger address raises `halt` where it should stay low.

// File: rtl/spr_dma_pkg.sv
`timescale 1ns/1ps
package spr_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_ALIGN = 3'd2,
    ST_RD    = 3'd3,
    ST_WR    = 3'd4
  } sdma_state_e;
endpackage

// File: rtl/spr_dma_phase.sv
`timescale 1ns/1ps
module spr_dma_phase (
  input  logic clk,
  input  logic rst,
  output logic put_phase
);
  always_ff @(posedge clk) begin
    if (rst) put_phase <= 1'b0;
    else     put_phase <= ~put_phase;
  end

  // R6: parity alternates on every cycle after reset
  assert_parity_toggles_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (put_phase != $past(put_phase)));
endmodule

// File: rtl/spr_dma_ctrl.sv
`timescale 1ns/1ps
module spr_dma_ctrl
  import spr_dma_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int TRIG_ADDR = 'h4014
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic              put_phase,
  input  logic              last,
  output sdma_state_e       st,
  output logic              page_ld
);
  localparam logic [ADDR_W-1:0] TRIG = ADDR_W'(TRIG_ADDR);

  sdma_state_e st_nx;
  logic        trig_hit;

  assign trig_hit = !cpu_rw && (cpu_addr == TRIG);
  assign page_ld  = trig_hit && (st == ST_IDLE || st == ST_WAIT);

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  if (trig_hit) st_nx = ST_WAIT;
      ST_WAIT:  if (cpu_rw) st_nx = put_phase ? ST_ALIGN : ST_RD;
      ST_ALIGN: st_nx = ST_RD;
      ST_RD:    st_nx = ST_WR;
      ST_WR:    st_nx = last ? ST_IDLE : ST_RD;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nx;
  end

  assert_arm_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && trig_hit) |=> (st == ST_WAIT));
  assert_wait_on_write_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && !cpu_rw) |=> (st == ST_WAIT));
  assert_no_align_get_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && cpu_rw && !put_phase) |=> (st == ST_RD));
  assert_align_put_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && cpu_rw && put_phase) |=> (st == ST_ALIGN));
  assert_read_then_write_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RD) |=> (st == ST_WR));
  assert_release_R8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WR && last) |=> (st == ST_IDLE));
endmodule

// File: rtl/spr_dma_xfer.sv
`timescale 1ns/1ps
module spr_dma_xfer
  import spr_dma_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PAIRS     = 256,
  parameter int PORT_ADDR = 'h2004
) (
  input  logic              clk,
  input  logic              rst,
  input  sdma_state_e       st,
  input  logic              page_ld,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              last,
  output logic [ADDR_W-1:0] dma_addr,
  output logic              dma_rw,
  output logic [DATA_W-1:0] dma_wdata
);
  localparam int IDX_W  = $clog2(PAIRS);
  localparam int PAGE_W = ADDR_W - IDX_W;
  localparam logic [ADDR_W-1:0] PORT = ADDR_W'(PORT_ADDR);

  logic [PAGE_W-1:0] page_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] byte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      idx_q  <= '0;
      byte_q <= '0;
    end else begin
      if (page_ld)     page_q <= cpu_wdata[PAGE_W-1:0];
      if (st == ST_RD) byte_q <= bus_rdata;
      if (st == ST_WR)        idx_q <= idx_q + 1'b1;
      else if (st == ST_IDLE) idx_q <= '0;
    end
  end

  assign last      = (idx_q == {IDX_W{1'b1}});
  assign dma_addr  = (st == ST_WR) ? PORT : {page_q, idx_q};
  assign dma_rw    = (st != ST_WR);
  assign dma_wdata = byte_q;

  // R7: the byte written is the byte read in the preceding cycle
  assert_copy_byte_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RD) |=> (dma_wdata == $past(bus_rdata)));
endmodule

// File: rtl/spr_dma.sv
`timescale 1ns/1ps
module spr_dma
  import spr_dma_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PAIRS     = 256,
  parameter int TRIG_ADDR = 'h4014,
  parameter int PORT_ADDR = 'h2004
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              halt,
  output logic              dma_active,
  output logic [ADDR_W-1:0] dma_addr,
  output logic              dma_rw,
  output logic [DATA_W-1:0] dma_wdata
);
  sdma_state_e st;
  logic        put_phase, last, page_ld;

  spr_dma_phase u_phase (.clk(clk), .rst(rst), .put_phase(put_phase));

  spr_dma_ctrl #(.ADDR_W(ADDR_W), .TRIG_ADDR(TRIG_ADDR)) u_ctrl (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .put_phase(put_phase), .last(last), .st(st), .page_ld(page_ld));

  spr_dma_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAIRS(PAIRS),
                 .PORT_ADDR(PORT_ADDR)) u_xfer (
    .clk(clk), .rst(rst), .st(st), .page_ld(page_ld), .cpu_wdata(cpu_wdata),
    .bus_rdata(bus_rdata), .last(last), .dma_addr(dma_addr), .dma_rw(dma_rw),
    .dma_wdata(dma_wdata));

  assign halt       = (st != ST_IDLE);
  assign dma_active = (st == ST_RD) || (st == ST_WR);

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (!halt && !dma_active));
  assert_master_only_halted_R7: assert property (@(posedge clk) disable iff (rst)
    dma_active |-> halt);
endmodule

// File: tb/tb_spr_dma.sv
`timescale 1ns/1ps
module tb_spr_dma;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = 16'h8000;
  logic        cpu_rw = 1'b1;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        halt, dma_active, dma_rw;
  logic [15:0] dma_addr;
  logic [7:0]  dma_wdata;

  int n_chk = 0, n_bad = 0;
  int unsigned cyc;
  bit done = 0;

  always #10 clk = ~clk;

  spr_dma dut (.clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .cpu_wdata(cpu_wdata), .bus_rdata(bus_rdata), .halt(halt),
    .dma_active(dma_active), .dma_addr(dma_addr), .dma_rw(dma_rw),
    .dma_wdata(dma_wdata));

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ {a[10:8], a[15:11]} ^ 8'hA5;
  endfunction

  always_comb bus_rdata = mem_f(dma_active ? dma_addr : cpu_addr);

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic rw, input logic [7:0] d);
    cpu_addr = a; cpu_rw = rw; cpu_wdata = d;
  endtask

  // vector: [11:4] page, [3:2] CPU writes after trigger, [1] parity of halted read, [0] writes hit trigger
  localparam logic [11:0] VEC [6] = '{
    {8'h00, 2'd0, 1'b0, 1'b0},
    {8'h03, 2'd0, 1'b1, 1'b0},
    {8'h7F, 2'd1, 1'b0, 1'b0},
    {8'hC2, 2'd2, 1'b1, 1'b0},
    {8'h10, 2'd2, 1'b0, 1'b1},
    {8'hFF, 2'd1, 1'b1, 1'b1}
  };

  task automatic run_case(input logic [7:0] page, input int nw, input bit par, input bit rmw);
    logic [7:0] exp_page;
    int k, halt_n, wait_n, rd_n, wr_n, xerr;
    logic [7:0] last_byte;
    exp_page = (rmw && nw > 0) ? ~page : page;
    // line up the parity of the halted read
    forever begin
      @(negedge clk);
      if (((cyc + nw + 1) % 2) == par) break;
      drive(16'h8000, 1'b1, 8'h00);
    end
    check(halt == 1'b0, "R2 idle before trigger", halt, 0);
    drive(16'h4014, 1'b0, page);
    k = 0; halt_n = 0; wait_n = 0; rd_n = 0; wr_n = 0; xerr = 0; last_byte = 8'h00;
    forever begin
      @(negedge clk);
      if (k == 0) check(halt == 1'b1, "R2 halt next cycle", halt, 1);
      if (!halt) break;
      halt_n++;
      if (!dma_active) wait_n++;
      else if (dma_rw) begin
        if (dma_addr != {exp_page, rd_n[7:0]}) xerr++;
        last_byte = mem_f(dma_addr);
        rd_n++;
      end else begin
        if (dma_addr != 16'h2004 || dma_wdata != last_byte) xerr++;
        wr_n++;
      end
      if (k < nw) drive(rmw ? 16'h4014 : 16'h0300, 1'b0, ~page);
      else        drive(16'h8123, 1'b1, 8'h00);
      k++;
      if (k > 2000) break;
    end
    // R3 R5 R6: stalled cycles without bus ownership
    check(wait_n == nw + 1 + int'(par), "R6 R5 R3 wait cycles", wait_n, nw + 1 + int'(par));
    check(xerr == 0, "R7 R4 address/data errors", xerr, 0);
    check(rd_n == 256 && wr_n == 256, "R7 pair count", rd_n, 256);
    check(halt_n == nw + 1 + int'(par) + 512, "R8 total halt cycles", halt_n,
          nw + 1 + int'(par) + 512);
    drive(16'h8123, 1'b1, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(halt == 0 && dma_active == 0, "R1 reset state", halt, 0);

    foreach (VEC[i]) run_case(VEC[i][11:4], int'(VEC[i][3:2]), VEC[i][1], VEC[i][0]);

    // R2: a read of the trigger address and a write elsewhere do not arm
    @(negedge clk); drive(16'h4014, 1'b1, 8'h55);
    @(negedge clk); check(halt == 0, "R2 read of trigger ignored", halt, 0);
    drive(16'h4015, 1'b0, 8'h55);
    @(negedge clk); check(halt == 0, "R2 other write ignored", halt, 0);
    drive(16'h8000, 1'b1, 8'h00);
    @(negedge clk); check(halt == 0, "R2 still idle", halt, 0);

    // R3: long run of CPU writes keeps the request waiting
    drive(16'h4014, 1'b0, 8'h20);
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      check(halt == 1 && dma_active == 0, "R3 waits during writes", dma_active, 0);
      drive(16'h0400, 1'b0, 8'h00);
    end
    @(negedge clk); drive(16'h8000, 1'b1, 8'h00);
    repeat (4) @(negedge clk);
    check(dma_active == 1, "R7 copy started after read", dma_active, 1);

    // R1: reset in the middle of a copy
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(halt == 0 && dma_active == 0, "R1 reset mid copy", halt, 0);
    @(negedge clk);
    check(halt == 0, "R1 stays idle", halt, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule